// File: doc/BRIEF.md
# Half-Line Vertical Sync Generator

This block produces the vertical timing of a camera video interface. A horizontal timing section supplies a one-cycle tick at every half-line. The block counts these ticks within a frame and drives a vertical sync pulse whose width and frame period are programmed in half-line units. This lets it produce interlaced frames with a half-line remainder, and sync pulses of a fractional line count, with no extra logic.

Both programmed lengths use an offset-by-one code. A frame length value N gives N+1 half-lines per frame. A sync value M keeps the pulse active for M+1 half-lines, so M = 2 × (sync lines) − 1. A 3-line pulse is M = 5 and a 2.5-line pulse is M = 4. The two lengths are taken into shadow registers only during reset and at the frame wrap. A frame in progress therefore always completes with the settings it started with.

The pulse level follows a polarity bit when the internal crystal timing mode is selected. In the external timing mode the pulse is always active low. An output enable parks the pin at its inactive level, and the counter and the internal pulse keep running. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `vsync_halfline_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `halfline_cnt` to 0 and drives `frame_start` and `sync_active` low. `sync_active` then stays low until the first frame wrap after reset.
- R2: `halfline_cnt` changes only on a clock edge where `half_tick` is 1. On any other edge it holds its value.
- R3: On a tick edge where `halfline_cnt` equals the latched frame length value N, the counter wraps to 0. Otherwise a tick adds one to it. A frame therefore lasts N+1 half-lines, so 0 gives 0.5 line and 4095 gives 2048 lines.
- R4: `frame_start` is 1 for the clock cycle that follows each wrap edge, and 0 in every other cycle. Whenever it is 1, `halfline_cnt` is 0.
- R5: Once the first wrap after reset has occurred, `sync_active` is 1 exactly while `halfline_cnt` ≤ M, where M is the latched 5-bit sync value. The pulse lasts M+1 half-lines, so M=5 gives 3 lines and M=4 gives 2.5 lines.
- R6: If M ≥ N, `sync_active` stays 1 for the whole frame. The pulse is cut at the frame wrap and a new pulse starts at count 0.
- R7: `cfg_frame_len` and `cfg_sync_len` are sampled only during reset and on wrap edges. A change at any other time does not alter the frame in progress.
- R8: The effective level is active high only when `cfg_internal` = 1 (internal crystal mode) and `cfg_pol_high` = 1. In every other case the level is active low and `vsync_out` = NOT `sync_active`. When active high, `vsync_out` = `sync_active`.
- R9: While `cfg_out_en` = 0, `vsync_out` sits at the inactive level: 1 for active low and 0 for active high. Counting and `sync_active` continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle pulse at each half-line |
| cfg_frame_len | input | 12 | Frame length value N, giving N+1 half-lines |
| cfg_sync_len | input | 5 | Sync width value M, giving M+1 half-lines |
| cfg_pol_high | input | 1 | 1 = active-high pulse (internal mode only) |
| cfg_internal | input | 1 | 1 = internal crystal timing, 0 = external timing |
| cfg_out_en | input | 1 | 1 = drive pulse on `vsync_out`, 0 = hold inactive |
| vsync_out | output | 1 | Vertical sync pin level |
| sync_active | output | 1 | Internal pulse, 1 while sync is in progress |
| frame_start | output | 1 | One-cycle strobe at count 0 of each new frame |
| halfline_cnt | output | 12 | Current half-line position within the frame |

## Verification
The assertions assume that `half_tick` is a synchronous one-cycle-per-event signal and that `rst` is held for at least one edge at start-up. They compare the count against the shadowed lengths, not against the live configuration inputs. The bench drives every input on the falling edge and gives each tick its own clock cycle. It inserts idle cycles between ticks so that holding and counting are both exercised. It changes configuration only between ticks and keeps every length within its field width.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef enum logic {
    LVL_ACTIVE_LOW  = 1'b0,
    LVL_ACTIVE_HIGH = 1'b1
  } vs_level_e;

  // Pin level for a given pulse state under a given active level
  function automatic logic pin_level(vs_level_e lvl, logic pulse);
    return (lvl == LVL_ACTIVE_HIGH) ? pulse : ~pulse;
  endfunction

  // Resting level of the pin for a given active level
  function automatic logic idle_level(vs_level_e lvl);
    return (lvl == LVL_ACTIVE_HIGH) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/vsg_shadow_regs.sv
module vsg_shadow_regs #(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  cfg_frame_len,
  input  logic [SYNC_W-1:0] cfg_sync_len,
  output logic [CNT_W-1:0]  flen_q,
  output logic [SYNC_W-1:0] sync_q
);

  // Lengths follow the inputs during reset and at frame wraps only
  always_ff @(posedge clk) begin
    if (rst || load) begin
      flen_q <= cfg_frame_len;
      sync_q <= cfg_sync_len;
    end
  end

endmodule

// File: rtl/vsg_halfline_counter.sv
module vsg_halfline_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_tick,
  input  logic [CNT_W-1:0] frame_len,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             frame_start
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign wrap = half_tick && (count == frame_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= wrap;
      if (half_tick) begin
        count <= wrap ? '0 : count + ONE;
      end
    end
  end

endmodule

// File: rtl/vsg_sync_shaper.sv
module vsg_sync_shaper #(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  count,
  input  logic [SYNC_W-1:0] sync_len,
  output logic              sync_active
);

  localparam int EXT_W = CNT_W + 1;

  logic             armed;
  logic [EXT_W-1:0] next_pos;
  logic [EXT_W-1:0] sync_ext;

  assign next_pos = {1'b0, count} + EXT_W'(1);
  assign sync_ext = EXT_W'(sync_len);

  // The pulse begins at every wrap; the first one comes only after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      sync_active <= 1'b0;
    end else if (wrap) begin
      armed       <= 1'b1;
      sync_active <= 1'b1;
    end else if (half_tick) begin
      sync_active <= armed && (next_pos <= sync_ext);
    end
  end

endmodule

// File: rtl/vsg_output_stage.sv
module vsg_output_stage
  import vsg_pkg::*;
(
  input  logic sync_active,
  input  logic cfg_pol_high,
  input  logic cfg_internal,
  input  logic cfg_out_en,
  output logic vsync_out
);

  vs_level_e lvl;

  // Polarity counts only in internal crystal timing
  assign lvl       = (cfg_internal && cfg_pol_high) ? LVL_ACTIVE_HIGH : LVL_ACTIVE_LOW;
  assign vsync_out = cfg_out_en ? pin_level(lvl, sync_active) : idle_level(lvl);

endmodule

// File: rtl/vsync_halfline_gen.sv
module vsync_halfline_gen #(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic [CNT_W-1:0]  cfg_frame_len,
  input  logic [SYNC_W-1:0] cfg_sync_len,
  input  logic              cfg_pol_high,
  input  logic              cfg_internal,
  input  logic              cfg_out_en,
  output logic              vsync_out,
  output logic              sync_active,
  output logic              frame_start,
  output logic [CNT_W-1:0]  halfline_cnt
);

  logic [CNT_W-1:0]  flen_q;
  logic [SYNC_W-1:0] sync_q;
  logic              wrap;

  vsg_shadow_regs #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_shadow (
    .clk           (clk),
    .rst           (rst),
    .load          (wrap),
    .cfg_frame_len (cfg_frame_len),
    .cfg_sync_len  (cfg_sync_len),
    .flen_q        (flen_q),
    .sync_q        (sync_q)
  );

  vsg_halfline_counter #(.CNT_W(CNT_W)) u_counter (
    .clk         (clk),
    .rst         (rst),
    .half_tick   (half_tick),
    .frame_len   (flen_q),
    .count       (halfline_cnt),
    .wrap        (wrap),
    .frame_start (frame_start)
  );

  vsg_sync_shaper #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_shaper (
    .clk         (clk),
    .rst         (rst),
    .half_tick   (half_tick),
    .wrap        (wrap),
    .count       (halfline_cnt),
    .sync_len    (sync_q),
    .sync_active (sync_active)
  );

  vsg_output_stage u_out (
    .sync_active  (sync_active),
    .cfg_pol_high (cfg_pol_high),
    .cfg_internal (cfg_internal),
    .cfg_out_en   (cfg_out_en),
    .vsync_out    (vsync_out)
  );

endmodule

// File: rtl/vsync_halfline_gen_chk.sv
module vsync_halfline_gen_chk #(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              half_tick,
  input logic              cfg_pol_high,
  input logic              cfg_internal,
  input logic              cfg_out_en,
  input logic              vsync_out,
  input logic              sync_active,
  input logic              frame_start,
  input logic [CNT_W-1:0]  halfline_cnt,
  input logic [CNT_W-1:0]  flen_q,
  input logic [SYNC_W-1:0] sync_q
);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(halfline_cnt));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (half_tick && halfline_cnt != flen_q) |=> (halfline_cnt == $past(halfline_cnt) + CNT_W'(1)));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (half_tick && halfline_cnt == flen_q) |=> (halfline_cnt == '0));

  // R4
  start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (halfline_cnt == '0));

  // R5
  pulse_window_chk: assert property (@(posedge clk) disable iff (rst)
    sync_active |-> (halfline_cnt <= CNT_W'(sync_q)));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    halfline_cnt <= flen_q);

  // R9
  pin_parked_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_out_en |-> (vsync_out == !(cfg_internal && cfg_pol_high)));

endmodule

bind vsync_halfline_gen vsync_halfline_gen_chk #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .half_tick    (half_tick),
  .cfg_pol_high (cfg_pol_high),
  .cfg_internal (cfg_internal),
  .cfg_out_en   (cfg_out_en),
  .vsync_out    (vsync_out),
  .sync_active  (sync_active),
  .frame_start  (frame_start),
  .halfline_cnt (halfline_cnt),
  .flen_q       (flen_q),
  .sync_q       (sync_q)
);

// File: tb/vsync_halfline_gen_test.sv
`timescale 1ns/1ps
module vsync_halfline_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        half_tick = 1'b0;
  logic [11:0] cfg_frame_len = 12'd9;
  logic [4:0]  cfg_sync_len = 5'd5;
  logic        cfg_pol_high = 1'b0;
  logic        cfg_internal = 1'b1;
  logic        cfg_out_en = 1'b1;
  logic        vsync_out, sync_active, frame_start;
  logic [11:0] halfline_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int  m_cnt, m_flen, m_slen;
  bit  m_armed, m_sync, m_fs;

  always #2 clk = ~clk;

  vsync_halfline_gen uut (
    .clk(clk), .rst(rst), .half_tick(half_tick),
    .cfg_frame_len(cfg_frame_len), .cfg_sync_len(cfg_sync_len),
    .cfg_pol_high(cfg_pol_high), .cfg_internal(cfg_internal),
    .cfg_out_en(cfg_out_en), .vsync_out(vsync_out),
    .sync_active(sync_active), .frame_start(frame_start),
    .halfline_cnt(halfline_cnt)
  );

  // {frame_len, sync_len, pol_high, internal, out_en}
  localparam int NVEC = 7;
  localparam logic [19:0] VECS [NVEC] = '{
    {12'd9,  5'd5,  3'b011},  // 3-line pulse, active low
    {12'd8,  5'd4,  3'b111},  // 2.5-line pulse, interlaced, active high
    {12'd3,  5'd10, 3'b111},  // pulse longer than frame
    {12'd0,  5'd0,  3'b011},  // half-line frame
    {12'd11, 5'd2,  3'b101},  // external mode, polarity ignored
    {12'd7,  5'd3,  3'b110},  // output disabled
    {12'd13, 5'd31, 3'b011}   // largest sync value, clipped
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_pin();
    bit hi;
    hi = cfg_internal && cfg_pol_high;
    if (!cfg_out_en) return !hi;
    return hi ? m_sync : !m_sync;
  endfunction

  task automatic check_all();
    chk("R2 R3 R7 count", halfline_cnt, m_cnt);
    chk("R4 frame_start", frame_start, m_fs);
    chk("R5 R6 sync_active", sync_active, m_sync);
    chk("R8 R9 vsync_out", vsync_out, exp_pin());
  endtask

  task automatic model_reset();
    m_cnt = 0; m_flen = cfg_frame_len; m_slen = cfg_sync_len;
    m_armed = 0; m_sync = 0; m_fs = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic do_tick();
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
    if (m_cnt == m_flen) begin
      m_cnt = 0; m_flen = cfg_frame_len; m_slen = cfg_sync_len;
      m_armed = 1; m_fs = 1;
    end else begin
      m_cnt++; m_fs = 0;
    end
    m_sync = m_armed && (m_cnt <= m_slen);
    check_all();
  endtask

  task automatic do_idle();
    @(negedge clk);
    m_fs = 0;
    check_all();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: state right after reset
    chk("R1 count", halfline_cnt, 0);
    chk("R1 sync_active", sync_active, 0);
    chk("R1 frame_start", frame_start, 0);
    chk("R1 vsync_out inactive", vsync_out, 1);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      cfg_frame_len = VECS[v][19:8];
      cfg_sync_len  = VECS[v][7:3];
      cfg_pol_high  = VECS[v][2];
      cfg_internal  = VECS[v][1];
      cfg_out_en    = VECS[v][0];
      for (int t = 0; t < 40; t++) begin
        do_tick();
        if (t % 3 == 2) do_idle();
      end
    end

    // R7: change lengths mid-frame; old frame length must hold
    cfg_frame_len = 12'd9; cfg_sync_len = 5'd5;
    cfg_pol_high = 1'b1; cfg_internal = 1'b1; cfg_out_en = 1'b1;
    while (m_cnt != 0 || m_flen != 9) do_tick();
    do_tick(); do_tick();
    cfg_frame_len = 12'd2; cfg_sync_len = 5'd0;
    for (int t = 0; t < 7; t++) do_tick();
    chk("R7 old length kept", halfline_cnt, 9);
    do_tick();
    chk("R7 wrap then new length", halfline_cnt, 0);
    chk("R4 strobe at wrap", frame_start, 1);
    do_idle();
    chk("R4 strobe one cycle", frame_start, 0);
    for (int t = 0; t < 9; t++) do_tick();

    // R1: reset mid-frame, then no pulse until first wrap
    do_tick();
    do_reset();
    chk("R1 count after reset", halfline_cnt, 0);
    chk("R1 sync after reset", sync_active, 0);
    do_tick(); do_tick();
    chk("R1 no pulse before wrap", sync_active, 0);
    do_tick();
    chk("R5 pulse at count 0", sync_active, 1);

    // R9: disable while pulse active, internal state keeps running
    cfg_out_en = 1'b0;
    @(negedge clk);
    chk("R9 pin parked low for active high", vsync_out, 0);
    chk("R9 sync_active unaffected", sync_active, 1);
    m_fs = 0;
    do_tick();
    chk("R9 counting continues", halfline_cnt, 1);

    // R8: external mode overrides polarity
    cfg_out_en = 1'b1; cfg_internal = 1'b0;
    @(negedge clk);
    chk("R8 external mode active low", vsync_out, !sync_active);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule